// File: doc/BRIEF.md
# Bit-addressed carry logic unit

This unit executes the single-bit instructions of a 4-bit microcontroller datapath. Each instruction names one bit of nibble-wide data memory through one of three addressing forms. The first is a direct form into the top page of memory. The second is an indirect peripheral form, where the L register supplies both the low nibble-address bits and the bit index. The third is a form relative to the H register. The unit reads the addressed nibble and then does one of two things. It can test the bit, ask the sequencer to skip the next instruction when the bit is set, and write the nibble back with that bit cleared. Or it can fold the bit into the carry flag with AND, OR or XOR.

Every instruction takes two cycles. In the accept cycle the unit samples the opcode, the addressing fields and H/L, and forms the address. In the execute cycle it drives a read of the nibble and computes the result from the returned data. For test-and-clear it also drives the write strobe, the write data and the skip request. The carry flag lives in the unit and shows its new value one cycle after the execute cycle. The sequencer uses the one-cycle skip pulse to squash the following instruction. Fetch, decode and the memory array sit outside the unit. The memory must return read data in the same cycle as the address (asynchronous read) and commit a write on the clock edge that ends the execute cycle.

Top module: `bit_carry_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the carry output is 0, and busy, mem_rd, mem_we and skip are all 0.
- R2: When op_valid is high and the unit is idle, the instruction is accepted. The next cycle is its only execute cycle, with busy and mem_rd high in that cycle. op_valid and all operand inputs are ignored during the execute cycle: the address, the operation and the outputs stay those of the accepted instruction, and no second instruction starts afterwards.
- R3: In direct mode (amode 0), and also for the reserved code amode 3, the nibble address is 0xF00 plus the 8-bit imm_addr field, and the bit index is imm_bit.
- R4: In peripheral mode (amode 1), the nibble address is 0xF00 plus the 8-bit value {imm_addr[7:2], reg_l[3:2]}, and the bit index is reg_l[1:0]. imm_addr[7:6]=2'b11 reaches the 0xFC0 to 0xFFF window.
- R5: In H-relative mode (amode 2), the nibble address is {4'h0, reg_h, imm_addr[3:0]}, and the bit index is imm_bit.
- R6: For op_code 1 (AND), 2 (OR) and 3 (XOR), the carry becomes the carry combined with the addressed bit by that operation. The new value is visible in the cycle after the execute cycle. These operations never assert mem_we.
- R7: For op_code 0 (test-and-clear), in the execute cycle mem_we is high, mem_wdata equals the read nibble with only the indexed bit forced to 0, and skip equals the original value of that bit. The carry is left unchanged.
- R8: skip and mem_we are high only in an execute cycle and never in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| op_valid | input | 1 | Instruction present for acceptance |
| op_code | input | 2 | 0 test-and-clear, 1 AND, 2 OR, 3 XOR |
| amode | input | 2 | 0 direct, 1 peripheral, 2 H-relative, 3 as direct |
| imm_addr | input | 8 | Address field from the instruction |
| imm_bit | input | 2 | Bit field from the instruction |
| reg_h | input | 4 | H register value |
| reg_l | input | 4 | L register value |
| busy | output | 1 | Execute cycle in progress |
| mem_addr | output | 12 | Nibble address to data memory |
| mem_rd | output | 1 | Read strobe (execute cycle) |
| mem_rdata | input | 4 | Nibble returned by memory, same cycle |
| mem_we | output | 1 | Write strobe, committed at the closing edge |
| mem_wdata | output | 4 | Nibble to write |
| skip | output | 1 | One-cycle request to squash the next instruction |
| cy | output | 1 | Carry flag |

## Verification
Directed instructions cover the cases that can be confused with one another. A test-and-clear on a set bit must skip, and one on a cleared bit must not. Chains of OR, AND and XOR on bits of known value take the carry through both levels, which separates the three operations. Peripheral and H-relative instructions use L and H values whose bit-index and address contributions differ, so a swapped field or a wrong window shows up in mem_addr. One instruction changes every input while the unit is busy, which shows that those inputs are ignored. A long random stream of modes, operations and register values is then checked against a behavioural model of the carry and of every written nibble.

// File: rtl/bcl_pkg.sv
package bcl_pkg;
  localparam int NIB_W   = 4;
  localparam int BIT_W   = 2;
  localparam int FIELD_W = 8;

  typedef enum logic [1:0] {
    BOP_TSTCLR = 2'd0,
    BOP_AND    = 2'd1,
    BOP_OR     = 2'd2,
    BOP_XOR    = 2'd3
  } bop_e;

  typedef enum logic [1:0] {
    AM_DIRECT = 2'd0,
    AM_PERIPH = 2'd1,
    AM_HREL   = 2'd2,
    AM_RSVD   = 2'd3
  } amode_e;
endpackage

// File: rtl/bcl_addr_gen.sv
module bcl_addr_gen
  import bcl_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic [1:0]         amode,
  input  logic [FIELD_W-1:0] imm_addr,
  input  logic [BIT_W-1:0]   imm_bit,
  input  logic [NIB_W-1:0]   reg_h,
  input  logic [NIB_W-1:0]   reg_l,
  output logic [AW-1:0]      addr,
  output logic [BIT_W-1:0]   bit_idx
);
  localparam int HI_W = AW - FIELD_W;
  localparam logic [AW-1:0] TOP_PAGE = {{HI_W{1'b1}}, {FIELD_W{1'b0}}};

  logic [FIELD_W-1:0] periph_off;
  logic [FIELD_W-1:0] hrel_off;

  assign periph_off = {imm_addr[FIELD_W-1:BIT_W], reg_l[NIB_W-1:BIT_W]};
  assign hrel_off   = {reg_h, imm_addr[NIB_W-1:0]};

  always_comb begin
    unique case (amode_e'(amode))
      AM_PERIPH: begin
        addr    = TOP_PAGE | {{HI_W{1'b0}}, periph_off};
        bit_idx = reg_l[BIT_W-1:0];
      end
      AM_HREL: begin
        addr    = {{HI_W{1'b0}}, hrel_off};
        bit_idx = imm_bit;
      end
      default: begin
        addr    = TOP_PAGE | {{HI_W{1'b0}}, imm_addr};
        bit_idx = imm_bit;
      end
    endcase
  end
endmodule

// File: rtl/bcl_bit_alu.sv
module bcl_bit_alu
  import bcl_pkg::*;
(
  input  logic [1:0]       op,
  input  logic [BIT_W-1:0] bit_idx,
  input  logic [NIB_W-1:0] rdata,
  input  logic             cy_cur,
  output logic             bit_val,
  output logic             cy_nxt,
  output logic [NIB_W-1:0] cleared
);
  assign bit_val = rdata[bit_idx];

  for (genvar i = 0; i < NIB_W; i++) begin : g_clr
    assign cleared[i] = rdata[i] & (bit_idx != BIT_W'(i));
  end

  always_comb begin
    unique case (bop_e'(op))
      BOP_AND: cy_nxt = cy_cur & bit_val;
      BOP_OR:  cy_nxt = cy_cur | bit_val;
      BOP_XOR: cy_nxt = cy_cur ^ bit_val;
      default: cy_nxt = cy_cur;
    endcase
  end
endmodule

// File: rtl/bit_carry_unit.sv
module bit_carry_unit
  import bcl_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               op_valid,
  input  logic [1:0]         op_code,
  input  logic [1:0]         amode,
  input  logic [FIELD_W-1:0] imm_addr,
  input  logic [BIT_W-1:0]   imm_bit,
  input  logic [NIB_W-1:0]   reg_h,
  input  logic [NIB_W-1:0]   reg_l,
  output logic               busy,
  output logic [AW-1:0]      mem_addr,
  output logic               mem_rd,
  input  logic [NIB_W-1:0]   mem_rdata,
  output logic               mem_we,
  output logic [NIB_W-1:0]   mem_wdata,
  output logic               skip,
  output logic               cy
);
  logic             busy_q, busy_d;
  logic             accept;
  logic [1:0]       op_q;
  logic [AW-1:0]    addr_q, addr_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic             cy_q, cy_d, cy_en;
  logic             bit_val;
  logic             is_clr;

  bcl_addr_gen #(.AW(AW)) u_addr (
    .amode    (amode),
    .imm_addr (imm_addr),
    .imm_bit  (imm_bit),
    .reg_h    (reg_h),
    .reg_l    (reg_l),
    .addr     (addr_d),
    .bit_idx  (bit_d)
  );

  bcl_bit_alu u_alu (
    .op      (op_q),
    .bit_idx (bit_q),
    .rdata   (mem_rdata),
    .cy_cur  (cy_q),
    .bit_val (bit_val),
    .cy_nxt  (cy_d),
    .cleared (mem_wdata)
  );

  always_comb begin
    accept = 1'b0;
    busy_d = 1'b0;
    if (!busy_q && op_valid) begin
      accept = 1'b1;
      busy_d = 1'b1;
    end
  end

  assign is_clr = (bop_e'(op_q) == BOP_TSTCLR);
  assign cy_en  = busy_q && !is_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      op_q   <= 2'd0;
      addr_q <= '0;
      bit_q  <= '0;
      cy_q   <= 1'b0;
    end else begin
      busy_q <= busy_d;
      if (accept) begin
        op_q   <= op_code;
        addr_q <= addr_d;
        bit_q  <= bit_d;
      end
      if (cy_en) begin
        cy_q <= cy_d;
      end
    end
  end

  assign busy     = busy_q;
  assign mem_addr = addr_q;
  assign mem_rd   = busy_q;
  assign mem_we   = busy_q && is_clr;
  assign skip     = busy_q && is_clr && bit_val;
  assign cy       = cy_q;
endmodule

// File: rtl/bcl_checker.sv
module bcl_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       mem_rd,
  input logic       mem_we,
  input logic [3:0] mem_rdata,
  input logic [3:0] mem_wdata,
  input logic       skip,
  input logic       cy
);
  assert_rd_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);

  assert_we_in_exec_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_rd);

  assert_skip_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    skip |=> !skip);

  assert_skip_writes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    skip |-> (mem_we && (mem_wdata != mem_rdata)));

  assert_clear_one_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (($countones(mem_wdata ^ mem_rdata) <= 1) && ((mem_wdata & ~mem_rdata) == 4'd0)));

  assert_cy_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && !mem_we) |=> $stable(cy));
endmodule

bind bit_carry_unit bcl_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_rd    (mem_rd),
  .mem_we    (mem_we),
  .mem_rdata (mem_rdata),
  .mem_wdata (mem_wdata),
  .skip      (skip),
  .cy        (cy)
);

// File: tb/bit_carry_unit_bench.sv
module bit_carry_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [1:0]  op_code, amode, imm_bit;
  logic [7:0]  imm_addr;
  logic [3:0]  reg_h, reg_l;
  logic        busy, mem_rd, mem_we, skip, cy;
  logic [11:0] mem_addr;
  logic [3:0]  mem_rdata, mem_wdata;
  logic [3:0]  dmem [0:4095];

  int n_chk  = 0;
  int n_fail = 0;
  int ref_cy = 0;

  always #4 clk = ~clk;

  bit_carry_unit u_bit_carry_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .amode(amode), .imm_addr(imm_addr), .imm_bit(imm_bit), .reg_h(reg_h),
    .reg_l(reg_l), .busy(busy), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .skip(skip), .cy(cy)
  );

  assign mem_rdata = dmem[mem_addr];
  always @(posedge clk) if (mem_we) dmem[mem_addr] <= mem_wdata;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  task automatic run_op(input int op, input int md, input int imm, input int bt,
                        input int h, input int l, input bit poke);
    int ea, bi, old, b, exp_nib;
    string areq;
    if (md == 1) begin
      ea = 'hF00 | (imm & 'hFC) | ((l >> 2) & 3); bi = l & 3; areq = "R4";
    end else if (md == 2) begin
      ea = (h << 4) | (imm & 'hF); bi = bt; areq = "R5";
    end else begin
      ea = 'hF00 | imm; bi = bt; areq = "R3";
    end
    old = int'(dmem[ea]);
    b   = (old >> bi) & 1;
    op_valid = 1'b1; op_code = op[1:0]; amode = md[1:0];
    imm_addr = imm[7:0]; imm_bit = bt[1:0]; reg_h = h[3:0]; reg_l = l[3:0];
    @(negedge clk);
    chk(busy && mem_rd, "R2", {busy, mem_rd}, 3);
    chk(mem_addr == ea[11:0], areq, mem_addr, ea);
    chk(mem_we == (op == 0), op == 0 ? "R7" : "R6", mem_we, op == 0);
    chk(skip == (op == 0 && b == 1), "R7", skip, (op == 0 && b == 1));
    if (op == 0) chk(mem_wdata == 4'(old & ~(1 << bi)), "R7", mem_wdata, old & ~(1 << bi));
    if (poke) begin
      op_code = 2'(op + 1); amode = 2'(md + 1); imm_addr = ~imm[7:0];
      imm_bit = ~bt[1:0]; reg_h = ~h[3:0]; reg_l = ~l[3:0];
    end else begin
      op_valid = 1'b0;
    end
    case (op)
      1: ref_cy = ref_cy & b;
      2: ref_cy = ref_cy | b;
      3: ref_cy = ref_cy ^ b;
      default: ;
    endcase
    exp_nib = (op == 0) ? (old & ~(1 << bi)) : old;
    @(negedge clk);
    op_valid = 1'b0;
    chk(cy == ref_cy[0], op == 0 ? "R7" : "R6", cy, ref_cy);
    chk(!busy && !mem_rd, "R2", {busy, mem_rd}, 0);
    chk(!skip && !mem_we, "R8", {skip, mem_we}, 0);
    chk(int'(dmem[ea]) == exp_nib, op == 0 ? "R7" : "R6", dmem[ea], exp_nib);
    if (poke) begin
      @(negedge clk);
      chk(!busy && !mem_rd && !mem_we, "R2", {busy, mem_rd, mem_we}, 0);
      chk(cy == ref_cy[0], "R2", cy, ref_cy);
    end
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
  end

  initial begin
    for (int i = 0; i < 4096; i++) dmem[i] = 4'($urandom);
    rst_n = 1'b0; op_valid = 1'b0; op_code = '0; amode = '0;
    imm_addr = '0; imm_bit = '0; reg_h = '0; reg_l = '0;
    repeat (3) @(negedge clk);
    chk(cy == 1'b0 && !busy && !mem_rd && !mem_we && !skip, "R1",
        {cy, busy, mem_rd, mem_we, skip}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cy == 1'b0 && !busy && !mem_rd && !mem_we && !skip, "R1",
        {cy, busy, mem_rd, mem_we, skip}, 0);

    // R7: set bit skips and clears, cleared bit does not skip
    dmem['hF25] = 4'b0100;
    run_op(0, 0, 'h25, 2, 0, 0, 0);
    run_op(0, 0, 'h25, 2, 0, 0, 0);
    // R6: drive carry through OR, AND, XOR
    dmem['hF10] = 4'b0010;
    run_op(2, 0, 'h10, 1, 0, 0, 0);
    run_op(1, 0, 'h10, 0, 0, 0, 0);
    run_op(3, 0, 'h10, 1, 0, 0, 0);
    run_op(3, 0, 'h10, 1, 0, 0, 0);
    run_op(2, 0, 'h10, 3, 0, 0, 0);
    // R4: peripheral window top nibble, bit from L
    dmem['hFFF] = 4'b0100;
    run_op(0, 1, 'hFD, 0, 9, 'hE, 0);
    run_op(2, 1, 'hC1, 3, 0, 'h5, 0);
    // R5: H-relative
    dmem['h05A] = 4'b1000;
    run_op(1, 2, 'h3A, 3, 5, 'hF, 0);
    run_op(0, 2, 'h3A, 3, 5, 0, 0);
    // R3: reserved mode code acts as direct
    run_op(3, 3, 'h81, 2, 'hA, 'h3, 0);
    // R2: inputs changed while busy are ignored
    dmem['hF44] = 4'b1111;
    run_op(0, 0, 'h44, 1, 0, 0, 1);
    run_op(3, 2, 'h17, 0, 3, 'h6, 1);

    for (int k = 0; k < 400; k++) begin
      run_op(int'($urandom % 4), int'($urandom % 4), int'($urandom % 256),
             int'($urandom % 4), int'($urandom % 16), int'($urandom % 16),
             ($urandom % 8) == 0);
    end
    summary();
  end
endmodule